// File: doc/BRIEF.md
# Interrupt Vector Sequencer

This block decides, at each instruction boundary, whether the processor core leaves its program for an interrupt handler, and then carries out the whole entry sequence on its own. Three kinds of source compete. The first is a level-sensitive maskable request, which is gated by the interrupt-enable flag. The second is an edge-triggered non-maskable request, which is latched until it is served. The third is a software trap raised by the instruction that is finishing. That instruction can also be a return-from-interrupt, which reverses an earlier entry.

On entry the block does the following, in order:
- If the maskable request won, it fetches an 8-bit type number through an acknowledge handshake.
- It pushes the flags word, the return code segment and the return instruction pointer onto the stack.
- It clears the enable flag.
- It reads the handler's instruction pointer and code segment from the vector table at four times the type.
- It presents the two values with a one-cycle jump strobe.

On return it pops the three words in reverse order, reloads the flags and strobes the jump again. The block owns the flags word and the stack pointer. All memory traffic goes through one word-wide request/acknowledge port. Stack accesses use physical address segment×16 + offset, and vector reads use an absolute address.

Top module: `irq_vec_seq`

## Requirements
- R1: After reset, busy_o, jump_o, inta_o and mem_req_o are low, flags_o is zero and sp_o equals SP_RST.
- R2: While the block is idle, a flags load (flags_ld_i) beats ie_clr_i, and ie_clr_i beats ie_set_i. The enable flag is bit IE_BIT (9). While busy_o is high, all three inputs are ignored.
- R3: Requests are considered only in a cycle where boundary_i is high and the block is idle. A maskable request (intr_i) is ignored unless the enable flag is set.
- R4: At one boundary the order of precedence is: a software trap that will be taken, then a return, then a pending non-maskable request, then the maskable request. A loser that is still pending (the non-maskable request) is served at a later boundary.
- R5: A rising edge on nmi_i marks a non-maskable request as pending. It is served with type 2 whatever the enable flag, and the pending mark clears when it is taken.
- R6: For a maskable entry, inta_o stays high until type_vld_i. The type is the byte on type_i in that cycle.
- R7: swi_kind_i selects the software trap. Code 00 uses swi_type_i as the type, code 01 uses type 3, and codes 1x use type 4 but only when the overflow flag (bit OF_BIT, 11) is set. Otherwise the trap has no effect.
- R8: Entry writes, in this order, the pre-entry flags, cur_cs_i and cur_ip_i, each at ss_i×16 + (SP−2). SP drops by 2 with each write.
- R9: The enable flag is cleared once the flags word is written, and all other flag bits are kept.
- R10: The handler's IP is read from address 4×type and its CS from 4×type+2. jump_o is then high for exactly one cycle, with ip_o and cs_o holding those words.
- R11: A return reads IP, CS and flags from ss_i×16 + SP, in that order, and SP rises by 2 after each read. jump_o then presents the restored IP and CS, and flags_o holds the restored word.
- R12: While mem_req_o is high and mem_ack_i is low, mem_addr_o, mem_we_o and mem_wdata_o hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| boundary_i | input | 1 | Instruction boundary; requests are sampled here |
| intr_i | input | 1 | Maskable request, level |
| nmi_i | input | 1 | Non-maskable request, rising edge |
| swi_req_i | input | 1 | Finishing instruction is a software trap |
| swi_kind_i | input | 2 | Trap form: 00 numbered, 01 breakpoint, 1x overflow |
| swi_type_i | input | TW | Type for the numbered form |
| iret_i | input | 1 | Finishing instruction is a return-from-interrupt |
| ie_set_i | input | 1 | Set the enable flag |
| ie_clr_i | input | 1 | Clear the enable flag |
| flags_ld_i | input | 1 | Load the whole flags word |
| flags_ld_data_i | input | WW | Flags value to load |
| cur_cs_i | input | WW | Return code segment |
| cur_ip_i | input | WW | Return instruction pointer |
| ss_i | input | WW | Stack segment |
| inta_o | output | 1 | Type fetch request |
| type_vld_i | input | 1 | type_i is valid |
| type_i | input | TW | Type byte from the external controller |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Write access |
| mem_addr_o | output | WW+4 | Physical byte address |
| mem_wdata_o | output | WW | Write word |
| mem_rdata_i | input | WW | Read word, valid with the acknowledge |
| mem_ack_i | input | 1 | Access complete |
| busy_o | output | 1 | Sequence in progress |
| jump_o | output | 1 | One-cycle strobe: ip_o and cs_o are valid |
| ip_o | output | WW | New instruction pointer |
| cs_o | output | WW | New code segment |
| sp_o | output | WW | Stack pointer |
| flags_o | output | WW | Flags word |

## Verification
On every cycle, the assertions check the following: the memory request holds while it waits, the acknowledge handshake holds, the stack pointer steps by one word per push, jump_o is a single pulse, and the enable flag is clear when a handler is entered. The same goes for idle flag operations and for the non-maskable request beating a maskable one at a boundary. Other behaviour needs the bench's scenarios. That covers the content and order of the pushed frame, the vector words fetched for a given type and the state a return restores. It also covers nesting several levels deep, a losing non-maskable request served at the next boundary, and the overflow trap with the overflow flag clear.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic [2:0] {
    W_NONE,
    W_SWI,
    W_RET,
    W_NMI,
    W_INTR
  } win_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_TYPE,
    S_PUSH_F,
    S_PUSH_CS,
    S_PUSH_IP,
    S_VEC_IP,
    S_VEC_CS,
    S_POP_IP,
    S_POP_CS,
    S_POP_F
  } seq_st_e;

endpackage

// File: rtl/irq_arb.sv
module irq_arb
  import irq_pkg::*;
#(
  parameter int unsigned TW       = 8,
  parameter int unsigned NMI_TYPE = 2,
  parameter int unsigned BRK_TYPE = 3,
  parameter int unsigned OVF_TYPE = 4
) (
  input  logic          boundary_i,
  input  logic          idle_i,
  input  logic          swi_req_i,
  input  logic [1:0]    swi_kind_i,
  input  logic [TW-1:0] swi_type_i,
  input  logic          iret_i,
  input  logic          nmi_pend_i,
  input  logic          intr_i,
  input  logic          ie_i,
  input  logic          of_i,
  output logic          take_o,
  output win_e          win_o,
  output logic [TW-1:0] type_o
);

  logic swi_go;

  // overflow form falls through when the overflow flag is clear
  assign swi_go = swi_req_i && (!swi_kind_i[1] || of_i);

  always_comb begin
    win_o  = W_NONE;
    type_o = '0;
    if (boundary_i && idle_i) begin
      if (swi_go) begin
        win_o = W_SWI;
        if (swi_kind_i[1])      type_o = TW'(OVF_TYPE);
        else if (swi_kind_i[0]) type_o = TW'(BRK_TYPE);
        else                    type_o = swi_type_i;
      end else if (iret_i) begin
        win_o = W_RET;
      end else if (nmi_pend_i) begin
        win_o  = W_NMI;
        type_o = TW'(NMI_TYPE);
      end else if (intr_i && ie_i) begin
        win_o = W_INTR;
      end
    end
  end

  assign take_o = (win_o != W_NONE);

endmodule

// File: rtl/irq_flags.sv
module irq_flags #(
  parameter int unsigned WW     = 16,
  parameter int unsigned IE_BIT = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          idle_i,
  input  logic          ie_set_i,
  input  logic          ie_clr_i,
  input  logic          ld_i,
  input  logic [WW-1:0] ld_data_i,
  input  logic          seq_clr_ie_i,
  input  logic          seq_ld_i,
  input  logic [WW-1:0] seq_ld_data_i,
  output logic [WW-1:0] flags_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_o <= '0;
    end else if (seq_ld_i) begin
      flags_o <= seq_ld_data_i;
    end else if (seq_clr_ie_i) begin
      flags_o[IE_BIT] <= 1'b0;
    end else if (idle_i) begin
      if (ld_i)          flags_o <= ld_data_i;
      else if (ie_clr_i) flags_o[IE_BIT] <= 1'b0;
      else if (ie_set_i) flags_o[IE_BIT] <= 1'b1;
    end
  end

endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_pkg::*;
#(
  parameter int unsigned WW     = 16,
  parameter int unsigned TW     = 8,
  parameter int unsigned SP_RST = 'h0200
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            take_i,
  input  win_e            win_i,
  input  logic [TW-1:0]   win_type_i,
  input  logic [WW-1:0]   flags_i,
  input  logic [WW-1:0]   cur_cs_i,
  input  logic [WW-1:0]   cur_ip_i,
  input  logic [WW-1:0]   ss_i,
  output logic            inta_o,
  input  logic            type_vld_i,
  input  logic [TW-1:0]   type_i,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [WW+3:0]   mem_addr_o,
  output logic [WW-1:0]   mem_wdata_o,
  input  logic [WW-1:0]   mem_rdata_i,
  input  logic            mem_ack_i,
  output logic            busy_o,
  output logic            jump_o,
  output logic [WW-1:0]   ip_o,
  output logic [WW-1:0]   cs_o,
  output logic [WW-1:0]   sp_o,
  output logic            clr_ie_o,
  output logic            restore_o,
  output logic [WW-1:0]   restore_data_o,
  output logic            ret_o
);

  localparam int unsigned AW = WW + 4;
  localparam logic [WW-1:0] WSTEP = WW'(2);

  seq_st_e         st_q;
  logic [TW-1:0]   type_q;
  logic [WW-1:0]   sp_q, ip_q, cs_q, rcs_q, rip_q;
  logic            jump_q, ret_q;
  logic            is_push, is_pop, is_vec, step;
  logic [WW-1:0]   stk_off;
  logic [AW-1:0]   vec_addr, stk_addr;

  assign is_push = (st_q == S_PUSH_F) || (st_q == S_PUSH_CS) || (st_q == S_PUSH_IP);
  assign is_pop  = (st_q == S_POP_IP) || (st_q == S_POP_CS) || (st_q == S_POP_F);
  assign is_vec  = (st_q == S_VEC_IP) || (st_q == S_VEC_CS);

  // pre-decrement on push, post-increment on pop
  assign stk_off  = is_push ? (sp_q - WSTEP) : sp_q;
  assign stk_addr = {ss_i, 4'h0} + AW'(stk_off);
  assign vec_addr = AW'({type_q, 2'b00}) + ((st_q == S_VEC_CS) ? AW'(2) : AW'(0));

  assign mem_req_o  = is_push || is_pop || is_vec;
  assign mem_we_o   = is_push;
  assign mem_addr_o = is_vec ? vec_addr : stk_addr;
  assign step       = mem_req_o && mem_ack_i;

  always_comb begin
    unique case (st_q)
      S_PUSH_F:  mem_wdata_o = flags_i;
      S_PUSH_CS: mem_wdata_o = rcs_q;
      S_PUSH_IP: mem_wdata_o = rip_q;
      default:   mem_wdata_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      type_q <= '0;
      sp_q   <= WW'(SP_RST);
      ip_q   <= '0;
      cs_q   <= '0;
      rcs_q  <= '0;
      rip_q  <= '0;
      jump_q <= 1'b0;
      ret_q  <= 1'b0;
    end else begin
      jump_q <= 1'b0;
      unique case (st_q)
        S_IDLE: if (take_i) begin
          rcs_q  <= cur_cs_i;
          rip_q  <= cur_ip_i;
          type_q <= win_type_i;
          ret_q  <= (win_i == W_RET);
          unique case (win_i)
            W_INTR:  st_q <= S_TYPE;
            W_RET:   st_q <= S_POP_IP;
            default: st_q <= S_PUSH_F;
          endcase
        end
        S_TYPE: if (type_vld_i) begin
          type_q <= type_i;
          st_q   <= S_PUSH_F;
        end
        S_PUSH_F: if (step) begin
          sp_q <= sp_q - WSTEP;
          st_q <= S_PUSH_CS;
        end
        S_PUSH_CS: if (step) begin
          sp_q <= sp_q - WSTEP;
          st_q <= S_PUSH_IP;
        end
        S_PUSH_IP: if (step) begin
          sp_q <= sp_q - WSTEP;
          st_q <= S_VEC_IP;
        end
        S_VEC_IP: if (step) begin
          ip_q <= mem_rdata_i;
          st_q <= S_VEC_CS;
        end
        S_VEC_CS: if (step) begin
          cs_q   <= mem_rdata_i;
          jump_q <= 1'b1;
          st_q   <= S_IDLE;
        end
        S_POP_IP: if (step) begin
          ip_q <= mem_rdata_i;
          sp_q <= sp_q + WSTEP;
          st_q <= S_POP_CS;
        end
        S_POP_CS: if (step) begin
          cs_q <= mem_rdata_i;
          sp_q <= sp_q + WSTEP;
          st_q <= S_POP_F;
        end
        S_POP_F: if (step) begin
          sp_q   <= sp_q + WSTEP;
          jump_q <= 1'b1;
          st_q   <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign inta_o         = (st_q == S_TYPE);
  assign busy_o         = (st_q != S_IDLE);
  assign jump_o         = jump_q;
  assign ip_o           = ip_q;
  assign cs_o           = cs_q;
  assign sp_o           = sp_q;
  assign clr_ie_o       = (st_q == S_PUSH_F) && step;
  assign restore_o      = (st_q == S_POP_F) && step;
  assign restore_data_o = mem_rdata_i;
  assign ret_o          = ret_q;

endmodule

// File: rtl/irq_vec_seq.sv
module irq_vec_seq
  import irq_pkg::*;
#(
  parameter int unsigned WW       = 16,
  parameter int unsigned TW       = 8,
  parameter int unsigned IE_BIT   = 9,
  parameter int unsigned OF_BIT   = 11,
  parameter int unsigned NMI_TYPE = 2,
  parameter int unsigned BRK_TYPE = 3,
  parameter int unsigned OVF_TYPE = 4,
  parameter int unsigned SP_RST   = 'h0200
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            boundary_i,
  input  logic            intr_i,
  input  logic            nmi_i,
  input  logic            swi_req_i,
  input  logic [1:0]      swi_kind_i,
  input  logic [TW-1:0]   swi_type_i,
  input  logic            iret_i,
  input  logic            ie_set_i,
  input  logic            ie_clr_i,
  input  logic            flags_ld_i,
  input  logic [WW-1:0]   flags_ld_data_i,
  input  logic [WW-1:0]   cur_cs_i,
  input  logic [WW-1:0]   cur_ip_i,
  input  logic [WW-1:0]   ss_i,
  output logic            inta_o,
  input  logic            type_vld_i,
  input  logic [TW-1:0]   type_i,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [WW+3:0]   mem_addr_o,
  output logic [WW-1:0]   mem_wdata_o,
  input  logic [WW-1:0]   mem_rdata_i,
  input  logic            mem_ack_i,
  output logic            busy_o,
  output logic            jump_o,
  output logic [WW-1:0]   ip_o,
  output logic [WW-1:0]   cs_o,
  output logic [WW-1:0]   sp_o,
  output logic [WW-1:0]   flags_o
);

  logic          nmi_q, nmi_pend_q;
  logic          take;
  win_e          win;
  logic [TW-1:0] win_type;
  logic          seq_clr_ie, seq_restore, seq_ret;
  logic [WW-1:0] seq_restore_data;

  // edge-latched non-maskable request; a new edge outlives a same-cycle take
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_q      <= 1'b0;
      nmi_pend_q <= 1'b0;
    end else begin
      nmi_q      <= nmi_i;
      nmi_pend_q <= (nmi_pend_q && !(take && win == W_NMI)) || (nmi_i && !nmi_q);
    end
  end

  irq_arb #(
    .TW(TW), .NMI_TYPE(NMI_TYPE), .BRK_TYPE(BRK_TYPE), .OVF_TYPE(OVF_TYPE)
  ) u_arb (
    .boundary_i (boundary_i),
    .idle_i     (!busy_o),
    .swi_req_i  (swi_req_i),
    .swi_kind_i (swi_kind_i),
    .swi_type_i (swi_type_i),
    .iret_i     (iret_i),
    .nmi_pend_i (nmi_pend_q),
    .intr_i     (intr_i),
    .ie_i       (flags_o[IE_BIT]),
    .of_i       (flags_o[OF_BIT]),
    .take_o     (take),
    .win_o      (win),
    .type_o     (win_type)
  );

  irq_flags #(.WW(WW), .IE_BIT(IE_BIT)) u_flags (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .idle_i        (!busy_o),
    .ie_set_i      (ie_set_i),
    .ie_clr_i      (ie_clr_i),
    .ld_i          (flags_ld_i),
    .ld_data_i     (flags_ld_data_i),
    .seq_clr_ie_i  (seq_clr_ie),
    .seq_ld_i      (seq_restore),
    .seq_ld_data_i (seq_restore_data),
    .flags_o       (flags_o)
  );

  irq_seq #(.WW(WW), .TW(TW), .SP_RST(SP_RST)) u_seq (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .take_i         (take),
    .win_i          (win),
    .win_type_i     (win_type),
    .flags_i        (flags_o),
    .cur_cs_i       (cur_cs_i),
    .cur_ip_i       (cur_ip_i),
    .ss_i           (ss_i),
    .inta_o         (inta_o),
    .type_vld_i     (type_vld_i),
    .type_i         (type_i),
    .mem_req_o      (mem_req_o),
    .mem_we_o       (mem_we_o),
    .mem_addr_o     (mem_addr_o),
    .mem_wdata_o    (mem_wdata_o),
    .mem_rdata_i    (mem_rdata_i),
    .mem_ack_i      (mem_ack_i),
    .busy_o         (busy_o),
    .jump_o         (jump_o),
    .ip_o           (ip_o),
    .cs_o           (cs_o),
    .sp_o           (sp_o),
    .clr_ie_o       (seq_clr_ie),
    .restore_o      (seq_restore),
    .restore_data_o (seq_restore_data),
    .ret_o          (seq_ret)
  );

endmodule

// File: rtl/irq_vec_seq_chk.sv
module irq_vec_seq_chk #(
  parameter int unsigned WW     = 16,
  parameter int unsigned IE_BIT = 9
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          boundary_i,
  input logic          intr_i,
  input logic          swi_req_i,
  input logic          iret_i,
  input logic          ie_set_i,
  input logic          ie_clr_i,
  input logic          flags_ld_i,
  input logic          inta_o,
  input logic          type_vld_i,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [WW+3:0] mem_addr_o,
  input logic [WW-1:0] mem_wdata_o,
  input logic          mem_ack_i,
  input logic          busy_o,
  input logic          jump_o,
  input logic [WW-1:0] sp_o,
  input logic [WW-1:0] flags_o,
  input logic          ret_i,
  input logic          nmi_pend_i
);

  AST_MEM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
                                && $stable(mem_wdata_o)); // R12

  AST_INTA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inta_o && !type_vld_i |=> inta_o); // R6

  AST_INTA_NEEDS_IE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(inta_o) |-> $past(flags_o[IE_BIT])); // R3

  AST_ENTRY_IE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jump_o && !ret_i |-> !flags_o[IE_BIT]); // R9

  AST_JUMP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jump_o |=> !jump_o); // R10

  AST_PUSH_SP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && mem_ack_i |=> sp_o == WW'($past(sp_o) - WW'(2))); // R8

  AST_IDLE_SET_IE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && ie_set_i && !ie_clr_i && !flags_ld_i |=> flags_o[IE_BIT]); // R2

  AST_NMI_BEATS_INTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boundary_i && !busy_o && nmi_pend_i && intr_i && !swi_req_i && !iret_i
    |=> busy_o && !inta_o); // R4

endmodule

bind irq_vec_seq irq_vec_seq_chk #(.WW(WW), .IE_BIT(IE_BIT)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .boundary_i  (boundary_i),
  .intr_i      (intr_i),
  .swi_req_i   (swi_req_i),
  .iret_i      (iret_i),
  .ie_set_i    (ie_set_i),
  .ie_clr_i    (ie_clr_i),
  .flags_ld_i  (flags_ld_i),
  .inta_o      (inta_o),
  .type_vld_i  (type_vld_i),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ack_i   (mem_ack_i),
  .busy_o      (busy_o),
  .jump_o      (jump_o),
  .sp_o        (sp_o),
  .flags_o     (flags_o),
  .ret_i       (seq_ret),
  .nmi_pend_i  (nmi_pend_q)
);

// File: tb/irq_vec_seq_tb_top.sv
module irq_vec_seq_tb_top;

  localparam int IE = 9;
  localparam int OF = 11;
  localparam logic [15:0] IEM = 16'h0200;
  localparam logic [15:0] SS  = 16'h0080;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boundary = 0, intr = 0, nmi = 0, swi_req = 0, iret = 0;
  logic [1:0]  swi_kind = '0;
  logic [7:0]  swi_type = '0, tvec = '0;
  logic        ie_set = 0, ie_clr = 0, flags_ld = 0;
  logic [15:0] flags_ld_data = '0, cur_cs = '0, cur_ip = '0;
  logic        inta, type_vld, mem_req, mem_we, mem_ack, busy, jump;
  logic [19:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata, ip_o, cs_o, sp_o, flags_o;

  logic [15:0] stk [0:1023];

  int nchk = 0, nbad = 0;
  logic [15:0] ef, esp, ecs, eip;
  logic [15:0] fr_ip [0:15], fr_cs [0:15], fr_fl [0:15];
  int depth = 0;

  irq_vec_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .boundary_i(boundary), .intr_i(intr), .nmi_i(nmi),
    .swi_req_i(swi_req), .swi_kind_i(swi_kind), .swi_type_i(swi_type), .iret_i(iret),
    .ie_set_i(ie_set), .ie_clr_i(ie_clr), .flags_ld_i(flags_ld),
    .flags_ld_data_i(flags_ld_data), .cur_cs_i(cur_cs), .cur_ip_i(cur_ip), .ss_i(SS),
    .inta_o(inta), .type_vld_i(type_vld), .type_i(tvec),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack),
    .busy_o(busy), .jump_o(jump), .ip_o(ip_o), .cs_o(cs_o), .sp_o(sp_o),
    .flags_o(flags_o)
  );

  always #4 clk = ~clk;

  function automatic logic [15:0] vip(input logic [7:0] t);
    return {t ^ 8'h3C, t + 8'h10};
  endfunction

  function automatic logic [15:0] vcs(input logic [7:0] t);
    return {~t, t};
  endfunction

  function automatic logic [9:0] sidx(input logic [15:0] off);
    logic [19:0] a;
    a = {SS, 4'h0} + {4'h0, off};
    return a[10:1];
  endfunction

  // memory and type-byte responders: one-cycle acknowledge
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack  <= 1'b0;
      type_vld <= 1'b0;
    end else begin
      mem_ack  <= mem_req && !mem_ack;
      type_vld <= inta && !type_vld;
      if (mem_req && !mem_ack)
        mem_rdata <= (mem_addr < 20'h400) ?
                     (mem_addr[1] ? vcs(mem_addr[9:2]) : vip(mem_addr[9:2])) :
                     stk[mem_addr[10:1]];
      if (mem_req && mem_ack && mem_we) stk[mem_addr[10:1]] <= mem_wdata;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic pulse(input bit sw, input logic [1:0] k, input logic [7:0] n, input bit ir);
    @(negedge clk);
    ecs = 16'($urandom); eip = 16'($urandom);
    cur_cs = ecs; cur_ip = eip;
    swi_req = sw; swi_kind = k; swi_type = n; iret = ir; boundary = 1;
    @(negedge clk);
    boundary = 0; swi_req = 0; iret = 0;
  endtask

  task automatic wait_jump(output bit got);
    got = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (jump) begin got = 1; break; end
    end
    if (!got) chk(0, "watch jump missing", 0, 1);
  endtask

  task automatic expect_entry(input logic [7:0] t, input string tag);
    bit got;
    wait_jump(got);
    if (got) begin
      chk(ip_o == vip(t), {tag, " R10 ip"}, ip_o, vip(t));
      chk(cs_o == vcs(t), {tag, " R10 cs"}, cs_o, vcs(t));
      chk(flags_o == (ef & ~IEM), {tag, " R9 flags"}, flags_o, ef & ~IEM);
      chk(sp_o == esp - 16'd6, {tag, " R8 sp"}, sp_o, esp - 16'd6);
      chk(stk[sidx(esp - 16'd2)] == ef, {tag, " R8 R12 pushed flags"}, stk[sidx(esp - 16'd2)], ef);
      chk(stk[sidx(esp - 16'd4)] == ecs, {tag, " R8 pushed cs"}, stk[sidx(esp - 16'd4)], ecs);
      chk(stk[sidx(esp - 16'd6)] == eip, {tag, " R8 pushed ip"}, stk[sidx(esp - 16'd6)], eip);
      fr_ip[depth] = eip; fr_cs[depth] = ecs; fr_fl[depth] = ef;
      depth++;
      ef = ef & ~IEM;
      esp = esp - 16'd6;
    end
  endtask

  task automatic do_iret(input string tag);
    bit got;
    pulse(0, 2'b00, 8'h00, 1);
    wait_jump(got);
    if (got) begin
      chk(ip_o == fr_ip[depth-1], {tag, " R11 ip"}, ip_o, fr_ip[depth-1]);
      chk(cs_o == fr_cs[depth-1], {tag, " R11 cs"}, cs_o, fr_cs[depth-1]);
      chk(flags_o == fr_fl[depth-1], {tag, " R11 flags"}, flags_o, fr_fl[depth-1]);
      chk(sp_o == esp + 16'd6, {tag, " R11 sp"}, sp_o, esp + 16'd6);
      ef = fr_fl[depth-1];
      esp = esp + 16'd6;
      depth--;
    end
  endtask

  task automatic quiet(input string tag);
    repeat (3) begin
      @(negedge clk);
      chk(!busy && !inta && !jump, tag, {busy, inta, jump}, 0);
    end
  endtask

  task automatic set_ie(input bit v);
    @(negedge clk); ie_set = v; ie_clr = !v;
    @(negedge clk); ie_set = 0; ie_clr = 0;
    ef[IE] = v;
  endtask

  task automatic load_flags(input logic [15:0] v);
    @(negedge clk); flags_ld = 1; flags_ld_data = v;
    @(negedge clk); flags_ld = 0;
    ef = v;
    chk(flags_o == v, "R2 flags load", flags_o, v);
  endtask

  task automatic nmi_edge();
    @(negedge clk); nmi = 1;
    @(negedge clk); nmi = 0;
  endtask

  initial begin
    #1_500_000;
    nchk++; nbad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !jump && !inta && !mem_req, "R1 idle outputs", {busy, jump, inta, mem_req}, 0);
    chk(flags_o == 16'h0, "R1 flags", flags_o, 0);
    chk(sp_o == 16'h0200, "R1 sp", sp_o, 16'h0200);
    ef = 16'h0; esp = 16'h0200;

    // R2 precedence of flag operations
    @(negedge clk); flags_ld = 1; flags_ld_data = 16'h0A05; ie_clr = 1; ie_set = 1;
    @(negedge clk); flags_ld = 0; ie_clr = 0; ie_set = 0;
    chk(flags_o == 16'h0A05, "R2 load beats set/clr", flags_o, 16'h0A05);
    @(negedge clk); ie_set = 1; ie_clr = 1;
    @(negedge clk); ie_set = 0; ie_clr = 0;
    chk(flags_o == 16'h0805, "R2 clr beats set", flags_o, 16'h0805);
    ef = 16'h0805;

    // R3 masked request and request without boundary
    intr = 1; tvec = 8'h47;
    quiet("R3 no boundary");
    pulse(0, 2'b00, 8'h00, 0);
    quiet("R3 masked intr ignored");
    intr = 0;

    // R6 maskable entry
    set_ie(1);
    chk(flags_o[IE] == 1'b1, "R2 set ie", flags_o[IE], 1);
    intr = 1; tvec = 8'h47;
    pulse(0, 2'b00, 8'h00, 0);
    intr = 0;
    expect_entry(8'h47, "R6 intr");
    do_iret("R11 from intr");

    // R5 non-maskable with enable clear
    set_ie(0);
    nmi_edge();
    pulse(0, 2'b00, 8'h00, 0);
    expect_entry(8'd2, "R5 nmi ie off");
    do_iret("R11 from nmi");

    // R4 non-maskable beats maskable
    set_ie(1);
    nmi_edge();
    intr = 1; tvec = 8'h55;
    pulse(0, 2'b00, 8'h00, 0);
    expect_entry(8'd2, "R4 nmi over intr");
    pulse(0, 2'b00, 8'h00, 0);
    quiet("R3 entry cleared ie");
    do_iret("R11 restores ie");
    pulse(0, 2'b00, 8'h00, 0);
    intr = 0;
    expect_entry(8'h55, "R4 intr after nmi");
    do_iret("R11 after intr");

    // R4 software trap beats pending non-maskable
    nmi_edge();
    pulse(1, 2'b00, 8'h21, 0);
    expect_entry(8'h21, "R4 swi first");
    pulse(0, 2'b00, 8'h00, 0);
    expect_entry(8'd2, "R5 nmi kept pending");
    pulse(0, 2'b00, 8'h00, 0);
    quiet("R5 pending cleared");
    do_iret("R11 nest2");
    do_iret("R11 nest1");

    // R7 trap forms
    load_flags(16'h0200);
    pulse(1, 2'b10, 8'h99, 0);
    quiet("R7 overflow clear no effect");
    load_flags(16'h0A00);
    pulse(1, 2'b11, 8'h99, 0);
    expect_entry(8'd4, "R7 overflow set");
    pulse(1, 2'b01, 8'h99, 0);
    expect_entry(8'd3, "R7 breakpoint");
    pulse(1, 2'b00, 8'hFF, 0);
    expect_entry(8'hFF, "R7 type ff");
    do_iret("R11 a"); do_iret("R11 b"); do_iret("R11 c");

    // R2 set ignored while busy
    pulse(1, 2'b00, 8'h00, 0);
    ie_set = 1;
    @(negedge clk); ie_set = 0;
    expect_entry(8'h00, "R7 type 0");
    chk(flags_o[IE] == 1'b0, "R2 set ignored while busy", flags_o[IE], 0);
    do_iret("R11 d");

    // random mix
    for (int it = 0; it < 60; it++) begin
      int r;
      logic [7:0] n;
      bit v;
      r = int'($urandom % 6);
      n = 8'($urandom);
      if (depth >= 6) r = 5;
      if (r == 5 && depth == 0) r = 0;
      case (r)
        0: begin pulse(1, 2'b00, n, 0); expect_entry(n, "R7 rnd num"); end
        1: begin pulse(1, 2'b01, n, 0); expect_entry(8'd3, "R7 rnd brk"); end
        2: begin
          load_flags(16'($urandom));
          pulse(1, 2'b10, n, 0);
          if (ef[OF]) expect_entry(8'd4, "R7 rnd ovf");
          else quiet("R7 rnd ovf off");
        end
        3: begin nmi_edge(); pulse(0, 2'b00, 8'h00, 0); expect_entry(8'd2, "R5 rnd nmi"); end
        4: begin
          v = 1'($urandom);
          set_ie(v);
          intr = 1; tvec = n;
          pulse(0, 2'b00, 8'h00, 0);
          intr = 0;
          if (v) expect_entry(n, "R6 rnd intr");
          else quiet("R3 rnd masked");
        end
        default: do_iret("R11 rnd");
      endcase
    end
    while (depth > 0) do_iret("R11 unwind");
    chk(sp_o == 16'h0200, "R11 sp back", sp_o, 16'h0200);

    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

endmodule